// File: doc/BRIEF.md
# Converter Register Target on a Two-Wire Serial Bus

This block is the bus-facing register front end of a small data converter. It watches an oversampled SCL/SDA pair in the system clock domain, recognises START and STOP, matches a 7-bit target address chosen by a three-way strap, and answers with an open-drain SDA pull. It never drives SCL. Behind the bus engine sit two 16-bit registers: a read-only conversion result and a read/write configuration word. A register pointer, loaded by the first data byte of every write, selects between them.

The conversion sequencer feeds results in through `conv_valid_i`/`conv_result_i`, reports an ongoing conversion on `conv_busy_i`, and receives the live configuration word, a single-shot start pulse, and a general-call reset pulse. A transaction that stalls for too long is abandoned, and the engine then waits for a fresh START.

Top module: `i2c_cfg_target`

## Requirements
- R1: The target address is latched at each START from `strap_i`: 0 gives 7'h48, 1 gives 7'h49, 2 gives 7'h4B, and 3 acts like 0. A matching address byte is acknowledged by pulling SDA low during the ninth clock.
- R2: An address byte that neither matches nor is the general-call write is not acknowledged, and all later bytes are ignored (no ACK, no register change) until the next START or STOP.
- R3: The first data byte of a write loads the pointer: 00h selects the conversion register and any other value selects the configuration register. The pointer keeps its value across transactions until a write changes it.
- R4: A configuration write is the pointer byte, then the high byte, then the low byte, each acknowledged. The register takes the new value on the low byte. Bytes after the third are acknowledged and discarded. Data bytes written while the pointer selects the conversion register change nothing.
- R5: A read returns the selected register high byte first, MSB first within each byte. While the master acknowledges, the target continues with the low byte and then starts the word again. A master NACK ends the read and releases SDA.
- R6: `conv_valid_i` stores `conv_result_i` into bits 15:4 of the conversion register. Bits 3:0 read as zero, and the register is zero after reset.
- R7: After reset the configuration reads 16'h8583. Bit 15 always reads as the inverse of `conv_busy_i`, and bits 14:0 are the stored value, also presented on `cfg_o`.
- R8: A committed configuration write with bit 15 set pulses `os_start_o` for one cycle, but only if `conv_busy_i` is low at the time of the commit.
- R9: The general-call address 00h with R/W=0 is acknowledged. If the next byte is 06h, the configuration, the conversion register and the pointer return to their reset values and `gc_rst_o` pulses. A general-call read is not acknowledged.
- R10: If a transaction is in progress and neither SCL nor SDA changes for `TIMEOUT_CYCLES` clocks, the engine returns to idle and answers nothing until a new START.
- R11: `sda_pull_o` only asserts after an SCL falling edge, never while SCL is high, and it is released on STOP and on timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| strap_i | input | 2 | Address strap: 0 low, 1 high, 2 tied to clock |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| conv_valid_i | input | 1 | New conversion result strobe |
| conv_result_i | input | 12 | Conversion result, two's complement |
| conv_busy_i | input | 1 | Sequencer is converting |
| cfg_o | output | 16 | Live configuration word |
| os_start_o | output | 1 | Single-shot start pulse |
| gc_rst_o | output | 1 | General-call reset pulse |

## Verification
The bench targets the pointer: it checks that the pointer persists across transactions, that out-of-range values are folded to the configuration register, and that a NACKed foreign address cannot move it. A design that latched the pointer on every byte, or listened after a NACK, returns the wrong register. It reads past the low byte to catch a design that wraps to garbage or drops SDA. It issues a single-shot write while the sequencer is busy, which a design missing the busy gate answers with a spurious start. It lets a transaction stall beyond the timeout and then continues clocking. A design without the timeout still acknowledges the stale byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int REG_W     = 16;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 7;
    localparam int BITCNT_W  = 4;

    localparam logic [REG_W-1:0]  CFG_RESET    = 16'h8583;
    localparam logic [ADDR_W-1:0] GC_ADDR      = 7'h00;
    localparam logic [BYTE_W-1:0] GC_RESET_CMD = 8'h06;

    typedef enum logic [1:0] {
        STRAP_LOW  = 2'd0,
        STRAP_HIGH = 2'd1,
        STRAP_SCL  = 2'd2,
        STRAP_RSVD = 2'd3
    } strap_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } tgt_state_t;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_WRITE,
        PH_READ,
        PH_GCALL
    } tgt_phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
        logic any_edge;
    } bus_ev_t;

    typedef struct packed {
        logic              ptr_we;
        logic              msb_we;
        logic              cfg_we;
        logic              gc_rst;
        logic [BYTE_W-1:0] data;
    } reg_wr_t;

    function automatic logic [ADDR_W-1:0] strap_addr(input strap_t s);
        case (s)
            STRAP_HIGH: strap_addr = 7'b1001001;
            STRAP_SCL:  strap_addr = 7'b1001011;
            default:    strap_addr = 7'b1001000;
        endcase
    endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev,
    output logic    scl_s
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] cur;
    logic [NLINES-1:0] prev;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain   <= '1;
                prev[g] <= 1'b1;
            end else begin
                chain   <= {chain[SYNC_STAGES-2:0], raw[g]};
                prev[g] <= chain[SYNC_STAGES-1];
            end
        end
        assign cur[g] = chain[SYNC_STAGES-1];
    end

    always_comb begin
        ev.scl_rise = cur[0] & ~prev[0];
        ev.scl_fall = ~cur[0] & prev[0];
        ev.start    = cur[0] & prev[0] & prev[1] & ~cur[1];
        ev.stop     = cur[0] & prev[0] & ~prev[1] & cur[1];
        ev.sda      = cur[1];
        ev.any_edge = |(cur ^ prev);
    end

    assign scl_s = cur[0];

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 2_500_000
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev,
    input  strap_t           strap,
    input  logic [REG_W-1:0] rd_word,
    output logic             sda_pull,
    output reg_wr_t          wr,
    output logic             tmo_hit
);
    localparam int TMO_W = $clog2(TIMEOUT_CYCLES + 1);

    tgt_state_t        st;
    tgt_phase_t        phase;
    logic [BITCNT_W-1:0] cnt;
    logic [BYTE_W-1:0] sr;
    logic [BYTE_W-1:0] tx_lsb;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        byte_idx;
    logic              rd_lsb;
    logic              mack;
    logic [TMO_W-1:0]  idle_cnt;

    assign tmo_hit = (idle_cnt == TMO_W'(TIMEOUT_CYCLES));

    always_ff @(posedge clk) begin
        if (rst || st == ST_IDLE || ev.any_edge) begin
            idle_cnt <= '0;
        end else if (!tmo_hit) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        wr <= '0;
        if (rst) begin
            st       <= ST_IDLE;
            phase    <= PH_ADDR;
            cnt      <= '0;
            sr       <= '0;
            tx_lsb   <= '0;
            addr_q   <= strap_addr(STRAP_LOW);
            byte_idx <= '0;
            rd_lsb   <= 1'b0;
            mack     <= 1'b0;
            sda_pull <= 1'b0;
        end else if (ev.start) begin
            st       <= ST_RX;
            phase    <= PH_ADDR;
            cnt      <= '0;
            byte_idx <= '0;
            sda_pull <= 1'b0;
            addr_q   <= strap_addr(strap);
        end else if (ev.stop || tmo_hit) begin
            st       <= ST_IDLE;
            sda_pull <= 1'b0;
        end else begin
            case (st)
                ST_RX: begin
                    if (ev.scl_rise && cnt != BITCNT_W'(BYTE_W)) begin
                        sr  <= {sr[BYTE_W-2:0], ev.sda};
                        cnt <= cnt + 1'b1;
                    end
                    if (ev.scl_fall && cnt == BITCNT_W'(BYTE_W)) begin
                        st       <= ST_RX_ACK;
                        sda_pull <= 1'b1;
                        case (phase)
                            PH_ADDR: begin
                                if (sr[BYTE_W-1:1] == addr_q) begin
                                    phase <= sr[0] ? PH_READ : PH_WRITE;
                                end else if (sr[BYTE_W-1:1] == GC_ADDR && !sr[0]) begin
                                    phase <= PH_GCALL;
                                end else begin
                                    st       <= ST_IGNORE;
                                    sda_pull <= 1'b0;
                                end
                            end
                            PH_WRITE: begin
                                wr.data   <= sr;
                                wr.ptr_we <= (byte_idx == 2'd0);
                                wr.msb_we <= (byte_idx == 2'd1);
                                wr.cfg_we <= (byte_idx == 2'd2);
                                if (byte_idx != 2'd3) byte_idx <= byte_idx + 1'b1;
                            end
                            PH_GCALL: begin
                                wr.gc_rst <= (byte_idx == 2'd0) && (sr == GC_RESET_CMD);
                                if (byte_idx != 2'd3) byte_idx <= byte_idx + 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (ev.scl_fall) begin
                        cnt <= '0;
                        if (phase == PH_READ) begin
                            st       <= ST_TX;
                            sr       <= rd_word[REG_W-1:BYTE_W];
                            tx_lsb   <= rd_word[BYTE_W-1:0];
                            rd_lsb   <= 1'b1;
                            sda_pull <= ~rd_word[REG_W-1];
                        end else begin
                            st       <= ST_RX;
                            sda_pull <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (cnt == BITCNT_W'(BYTE_W-1)) begin
                            st       <= ST_TX_ACK;
                            cnt      <= '0;
                            sda_pull <= 1'b0;
                        end else begin
                            sr       <= {sr[BYTE_W-2:0], 1'b0};
                            sda_pull <= ~sr[BYTE_W-2];
                            cnt      <= cnt + 1'b1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (ev.scl_rise) mack <= ~ev.sda;
                    if (ev.scl_fall) begin
                        if (mack) begin
                            st <= ST_TX;
                            if (rd_lsb) begin
                                sr       <= tx_lsb;
                                sda_pull <= ~tx_lsb[BYTE_W-1];
                                rd_lsb   <= 1'b0;
                            end else begin
                                sr       <= rd_word[REG_W-1:BYTE_W];
                                tx_lsb   <= rd_word[BYTE_W-1:0];
                                sda_pull <= ~rd_word[REG_W-1];
                                rd_lsb   <= 1'b1;
                            end
                        end else begin
                            st <= ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  reg_wr_t             wr,
    input  logic                conv_valid_i,
    input  logic [RES_BITS-1:0] conv_result_i,
    input  logic                conv_busy_i,
    output logic [REG_W-1:0]    rd_word,
    output logic [REG_W-1:0]    cfg_o,
    output logic                os_start_o,
    output logic                gc_rst_o
);
    localparam int PAD_W = REG_W - RES_BITS;

    logic                ptr_cfg;
    logic [BYTE_W-1:0]   msb_hold;
    logic [REG_W-2:0]    cfg_q;
    logic [RES_BITS-1:0] conv_q;

    always_ff @(posedge clk) begin
        os_start_o <= 1'b0;
        gc_rst_o   <= 1'b0;
        if (rst || wr.gc_rst) begin
            ptr_cfg  <= 1'b0;
            msb_hold <= '0;
            cfg_q    <= CFG_RESET[REG_W-2:0];
            conv_q   <= '0;
            gc_rst_o <= wr.gc_rst && !rst;
        end else begin
            if (wr.ptr_we) ptr_cfg <= (wr.data != '0);
            if (wr.msb_we) msb_hold <= wr.data;
            if (wr.cfg_we && ptr_cfg) begin
                cfg_q      <= {msb_hold[BYTE_W-2:0], wr.data};
                os_start_o <= msb_hold[BYTE_W-1] & ~conv_busy_i;
            end
            if (conv_valid_i) conv_q <= conv_result_i;
        end
    end

    assign cfg_o   = {~conv_busy_i, cfg_q};
    assign rd_word = ptr_cfg ? cfg_o : {conv_q, {PAD_W{1'b0}}};

endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int RES_BITS       = 12,
    parameter int TIMEOUT_CYCLES = 2_500_000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic [1:0]          strap_i,
    output logic                sda_pull_o,
    input  logic                conv_valid_i,
    input  logic [RES_BITS-1:0] conv_result_i,
    input  logic                conv_busy_i,
    output logic [15:0]         cfg_o,
    output logic                os_start_o,
    output logic                gc_rst_o
);
    bus_ev_t          ev;
    logic             scl_s;
    reg_wr_t          wr;
    logic             tmo_hit;
    logic [REG_W-1:0] rd_word;

    i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev),
        .scl_s (scl_s)
    );

    i2c_tgt_fsm #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .strap    (strap_t'(strap_i)),
        .rd_word  (rd_word),
        .sda_pull (sda_pull_o),
        .wr       (wr),
        .tmo_hit  (tmo_hit)
    );

    i2c_tgt_regs #(.RES_BITS(RES_BITS)) u_regs (
        .clk           (clk),
        .rst           (rst),
        .wr            (wr),
        .conv_valid_i  (conv_valid_i),
        .conv_result_i (conv_result_i),
        .conv_busy_i   (conv_busy_i),
        .rd_word       (rd_word),
        .cfg_o         (cfg_o),
        .os_start_o    (os_start_o),
        .gc_rst_o      (gc_rst_o)
    );

endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker (
    input logic        clk,
    input logic        rst,
    input logic        sda_pull_o,
    input logic        scl_s,
    input logic        stop_evt,
    input logic        tmo_hit,
    input logic        gc_rst_o,
    input logic [15:0] cfg_o,
    input logic        os_start_o,
    input logic        conv_busy_i
);
    // R11: pull only begins after the synchronised clock was seen low
    a_r11_pull_after_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> !$past(scl_s));

    // R11: STOP frees the data line
    a_r11_release_on_stop: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !sda_pull_o);

    // R10: an expired idle window frees the data line
    a_r10_timeout_release: assert property (@(posedge clk) disable iff (rst)
        tmo_hit |=> !sda_pull_o);

    // R9: general-call reset leaves the configuration at its reset value
    a_r9_gc_restores_cfg: assert property (@(posedge clk) disable iff (rst)
        gc_rst_o |-> cfg_o[14:0] == 15'h0583);

    // R8: single-shot start only when the sequencer was idle
    a_r8_os_only_idle: assert property (@(posedge clk) disable iff (rst)
        os_start_o |-> $past(!conv_busy_i));
endmodule

bind i2c_cfg_target i2c_tgt_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .sda_pull_o  (sda_pull_o),
    .scl_s       (scl_s),
    .stop_evt    (ev.stop),
    .tmo_hit     (tmo_hit),
    .gc_rst_o    (gc_rst_o),
    .cfg_o       (cfg_o),
    .os_start_o  (os_start_o),
    .conv_busy_i (conv_busy_i)
);

// File: tb/i2c_cfg_target_test.sv
module i2c_cfg_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int TMO        = 3000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic [1:0] strap = 2'd0;
    logic conv_valid = 1'b0;
    logic [11:0] conv_result = '0;
    logic conv_busy = 1'b0;
    logic sda_pull;
    logic [15:0] cfg;
    logic os_start, gc_rst;
    logic sda_line;

    int checks = 0;
    int failures = 0;
    int os_cnt = 0;
    int gc_cnt = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = m_sda & ~sda_pull;

    i2c_cfg_target #(.TIMEOUT_CYCLES(TMO)) uut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .strap_i(strap),
        .sda_pull_o(sda_pull), .conv_valid_i(conv_valid), .conv_result_i(conv_result),
        .conv_busy_i(conv_busy), .cfg_o(cfg), .os_start_o(os_start), .gc_rst_o(gc_rst)
    );

    always @(posedge clk) begin
        if (os_start) os_cnt <= os_cnt + 1;
        if (gc_rst) gc_cnt <= gc_cnt + 1;
    end

    // R11 monitor: the target must never start pulling while SCL is high
    logic pull_d = 1'b0;
    always @(posedge clk) begin
        pull_d <= sda_pull;
        if (!rst && sda_pull && !pull_d && m_scl) begin
            failures <= failures + 1;
            $display("FAIL R11 pull rose while SCL high: act=1 exp=0");
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = sda_line; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        get_bit(x);
        ack = !x;
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) get_bit(d[i]);
        send_bit(!give_ack);
    endtask

    task automatic set_ptr(input logic [6:0] a, input logic [7:0] p, output logic ok);
        logic k1, k2;
        bus_start(); wbyte({a, 1'b0}, k1); wbyte(p, k2); bus_stop();
        ok = k1 & k2;
    endtask

    task automatic write3(input logic [6:0] a, input logic [7:0] p, input logic [7:0] hi,
                          input logic [7:0] lo, output logic ok);
        logic k1, k2, k3, k4;
        bus_start(); wbyte({a, 1'b0}, k1); wbyte(p, k2); wbyte(hi, k3); wbyte(lo, k4); bus_stop();
        ok = k1 & k2 & k3 & k4;
    endtask

    task automatic read_word(input logic [6:0] a, output logic ack, output logic [15:0] w);
        bus_start(); wbyte({a, 1'b1}, ack);
        if (ack) begin
            rbyte(1'b1, w[15:8]); rbyte(1'b0, w[7:0]);
        end else begin
            w = 16'hxxxx;
        end
        bus_stop();
    endtask

    task automatic addr_probe(input logic [6:0] a, output logic ack);
        bus_start(); wbyte({a, 1'b0}, ack); bus_stop();
    endtask

    task automatic t_reset();
        check("R7 cfg reset", cfg, 16'h8583);
        check("R11 idle release", sda_pull, 1'b0);
    endtask

    task automatic t_conv_read();
        logic ok, ack; logic [15:0] w;
        @(posedge clk); #1 conv_result = 12'h123; conv_valid = 1'b1;
        @(posedge clk); #1 conv_valid = 1'b0;
        set_ptr(7'h48, 8'h00, ok);
        check("R1 strap low ack 0x48", ok, 1'b1);
        read_word(7'h48, ack, w);
        check("R6 conversion readback", w, 16'h1230);
    endtask

    task automatic t_strap();
        logic ack;
        strap = 2'd1;
        addr_probe(7'h48, ack); check("R1 strap high nack 0x48", ack, 1'b0);
        addr_probe(7'h49, ack); check("R1 strap high ack 0x49", ack, 1'b1);
        strap = 2'd2;
        addr_probe(7'h4B, ack); check("R1 strap scl ack 0x4B", ack, 1'b1);
        addr_probe(7'h49, ack); check("R1 strap scl nack 0x49", ack, 1'b0);
        strap = 2'd3;
        addr_probe(7'h48, ack); check("R1 strap 3 acts as low", ack, 1'b1);
        strap = 2'd0;
    endtask

    task automatic t_foreign();
        logic k1, k2, ack; logic [15:0] w;
        bus_start(); wbyte({7'h50, 1'b0}, k1); wbyte(8'h01, k2); bus_stop();
        check("R2 foreign address nack", k1, 1'b0);
        check("R2 byte after nack ignored", k2, 1'b0);
        read_word(7'h48, ack, w);
        check("R2 pointer untouched", w, 16'h1230);
    endtask

    task automatic t_cfg_write();
        logic k1, k2, k3, k4, k5, ack; logic [7:0] b0, b1, b2;
        bus_start(); wbyte({7'h48, 1'b0}, k1); wbyte(8'h01, k2); wbyte(8'h05, k3);
        wbyte(8'h03, k4); wbyte(8'hFF, k5); bus_stop();
        check("R4 all bytes acked", {k1, k2, k3, k4, k5}, 5'b11111);
        check("R4 cfg committed", cfg, 16'h8503);
        check("R8 no start for bit15 clear", os_cnt, 0);
        bus_start(); wbyte({7'h48, 1'b1}, ack);
        rbyte(1'b1, b0); rbyte(1'b1, b1); rbyte(1'b0, b2);
        bus_stop();
        check("R5 high byte first", b0, 8'h85);
        check("R5 low byte second", b1, 8'h03);
        check("R5 wraps to high byte", b2, 8'h85);
        check("R5 released after nack", sda_pull, 1'b0);
    endtask

    task automatic t_pointer();
        logic ok, ack; logic [15:0] w;
        read_word(7'h48, ack, w);
        check("R3 pointer sticky", w, 16'h8503);
        set_ptr(7'h48, 8'h00, ok);
        read_word(7'h48, ack, w);
        check("R3 pointer 00 selects conversion", w, 16'h1230);
        set_ptr(7'h48, 8'h07, ok);
        read_word(7'h48, ack, w);
        check("R3 pointer 07 selects configuration", w, 16'h8503);
        write3(7'h48, 8'h00, 8'hAA, 8'hBB, ok);
        check("R4 write to conversion acked", ok, 1'b1);
        read_word(7'h48, ack, w);
        check("R4 conversion register unchanged", w, 16'h1230);
        check("R4 cfg unchanged", cfg, 16'h8503);
    endtask

    task automatic t_single_shot();
        logic ok, ack; logic [15:0] w;
        write3(7'h48, 8'h01, 8'h85, 8'h83, ok);
        repeat (4) @(posedge clk); #1;
        check("R8 start pulse when idle", os_cnt, 1);
        conv_busy = 1'b1;
        write3(7'h48, 8'h01, 8'h85, 8'h83, ok);
        repeat (4) @(posedge clk); #1;
        check("R8 no start while busy", os_cnt, 1);
        read_word(7'h48, ack, w);
        check("R7 bit15 reads busy", w, 16'h0583);
        conv_busy = 1'b0;
    endtask

    task automatic t_gcall();
        logic ok, k1, k2, ack; logic [15:0] w;
        write3(7'h48, 8'h01, 8'h01, 8'h23, ok);
        check("R4 cfg before gc", cfg, 16'h8123);
        bus_start(); wbyte(8'h00, k1); wbyte(8'h06, k2); bus_stop();
        check("R9 gc address acked", k1 & k2, 1'b1);
        check("R9 gc pulse", gc_cnt, 1);
        check("R9 cfg restored", cfg, 16'h8583);
        read_word(7'h48, ack, w);
        check("R9 pointer and conversion cleared", w, 16'h0000);
        bus_start(); wbyte(8'h01, k1); bus_stop();
        check("R9 gc read nacked", k1, 1'b0);
    endtask

    task automatic t_timeout();
        logic k1, k2;
        bus_start(); wbyte({7'h48, 1'b0}, k1);
        repeat (TMO + 100) @(posedge clk); #1;
        check("R10 line released after stall", sda_pull, 1'b0);
        wbyte(8'h01, k2); bus_stop();
        check("R10 addr acked before stall", k1, 1'b1);
        check("R10 stale byte not acked", k2, 1'b0);
        addr_probe(7'h48, k1);
        check("R10 new start answered", k1, 1'b1);
    endtask

    initial begin
        repeat (5) @(posedge clk); #1;
        rst = 1'b0;
        repeat (5) @(posedge clk); #1;
        t_reset();
        t_conv_read();
        t_strap();
        t_foreign();
        t_cfg_write();
        t_pointer();
        t_single_shot();
        t_gcall();
        t_timeout();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired: act=running exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule